// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side master for a delta-sigma converter that returns each conversion as a 24-bit serial frame. The controller drives the converter's chip-select low with the serial clock idle. While chip-select is low and the clock is idle, the converter's data line shows a live conversion-busy level. The controller samples that level through a two-flop synchronizer and waits for it to fall. It then generates 24 clock pulses with a 50% duty cycle from the system clock, captures one frame bit per pulse, and releases chip-select. After that it keeps chip-select high for a minimum gap before it polls again.

The captured frame is decoded into a 22-bit two's complement sample, overrange and underrange flags, and a framing-error flag. The result goes out on a valid/ready stream. `res_valid` stays high with the payload frozen until `res_ready` is sampled high on a clock edge. While a result is still waiting, no new read starts, so back-pressure stalls the converter interface rather than dropping data. A one-cycle interrupt can mark the moment the busy level is seen low. If the busy level never falls, a timeout ends the poll with an error pulse.

Top module: `adc_rd_ctrl`

## Requirements
- R1: Out of reset `adc_csn` is 1, `adc_sck` is 0, `res_valid` is 0, and `irq` and `tmo_err` are 0.
- R2: After driving `adc_csn` low, the controller issues no `adc_sck` edge while `adc_sdo` is high. It starts clocking only after `adc_sdo` is seen low.
- R3: One read consists of exactly 24 rising edges of `adc_sck` while `adc_csn` is low. `adc_sck` is 0 whenever `adc_csn` is 1.
- R4: Frame bits are taken MSB first, one per `adc_sck` rising edge: first frame[23], last frame[0]. `res_data` = {~frame[21], frame[20:0]}. This means a sign bit of 1 gives a value of 0 or above, and a sign bit of 0 gives a negative value.
- R5: `res_ovr` = frame[21] & frame[20], and `res_udr` = ~frame[21] & ~frame[20]. The two are never high together.
- R6: `res_ferr` is 1 exactly when the always-zero frame bit 22 was read as 1. The data and range fields are still delivered.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and all payload fields hold their values. No read starts (`adc_csn` stays 1) until the result has been accepted.
- R8: After every read, and after every timeout, `adc_csn` stays high for at least CS_GAP cycles before it falls again.
- R9: If `adc_sdo` stays high for TMO_CYC cycles of polling, `tmo_err` pulses for one cycle, `adc_csn` returns high, no `adc_sck` pulse is issued and no result is produced.
- R10: `irq` pulses for one cycle when the low busy level is accepted, and only if `irq_en` was 1. With `irq_en` at 0, `irq` stays 0.
- R11: Each `adc_sck` pulse is high for exactly SCK_HALF cycles, and successive rising edges are 2*SCK_HALF cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | Enables the conversion-done interrupt pulse |
| adc_sdo | input | 1 | Serial data / busy level from converter |
| adc_csn | output | 1 | Converter chip-select, active low |
| adc_sck | output | 1 | Serial clock to converter, idle low |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_data | output | 22 | Two's complement sample |
| res_ovr | output | 1 | Input above positive full scale |
| res_udr | output | 1 | Input below negative full scale |
| res_ferr | output | 1 | Dummy bit read as 1 |
| irq | output | 1 | One-cycle conversion-done pulse |
| tmo_err | output | 1 | One-cycle busy-timeout pulse |

## Verification
Some properties are checked on every cycle. These are the serial clock staying low with chip-select high, the pulse count per chip-select window being 24 or zero, the high time of each clock pulse, the minimum chip-select gap, the stability of a stalled result, the mutual exclusion of the range flags, and the conditions under which the interrupt and timeout pulses may appear. Other behaviours need a modelled converter, so only the bench scenarios can show them. These are the bit order, the decoding of the value and flags for each frame, the absence of clocking while the busy level is high, recovery after a timeout, and silence of the interrupt when it is disabled.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int FRAME_W = 24;
  localparam int DATA_W  = 21;
  localparam int RES_W   = DATA_W + 1;
  localparam int SIGN_B  = 21;
  localparam int DUMMY_B = 22;

  typedef enum logic [1:0] {
    ST_GAP   = 2'd0,
    ST_POLL  = 2'd1,
    ST_SHIFT = 2'd2
  } rd_state_t;

  typedef struct packed {
    logic [RES_W-1:0] value;
    logic             ovr;
    logic             udr;
    logic             ferr;
  } rd_result_t;
endpackage

// File: rtl/adc_sdo_sync.sv
module adc_sdo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= din;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic cap
);
  localparam int PERIOD = 2 * HALF;
  localparam int PH_W   = $clog2(PERIOD);

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_n;

  always_comb begin
    if (ph == PH_W'(PERIOD - 1)) ph_n = '0;
    else                         ph_n = ph + 1'b1;
  end

  // capture strobe marks the last cycle of the high phase
  assign cap = run && (ph == PH_W'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      ph  <= '0;
      sck <= 1'b0;
    end else begin
      ph  <= ph_n;
      sck <= (ph_n >= PH_W'(HALF));
    end
  end
endmodule

// File: rtl/adc_frame_dec.sv
module adc_frame_dec
  import adc_rd_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  output rd_result_t         res
);
  logic sgn, top;

  assign sgn = frame[SIGN_B];
  assign top = frame[DATA_W-1];

  always_comb begin
    res.value = {~sgn, frame[DATA_W-1:0]};
    res.ovr   = sgn & top;
    res.udr   = ~sgn & ~top;
    res.ferr  = frame[DUMMY_B];
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int SCK_HALF = 4,
  parameter int CS_GAP   = 16,
  parameter int TMO_CYC  = 100000,
  parameter int SETTLE   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_en,
  input  logic             adc_sdo,
  output logic             adc_csn,
  output logic             adc_sck,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RES_W-1:0] res_data,
  output logic             res_ovr,
  output logic             res_udr,
  output logic             res_ferr,
  output logic             irq,
  output logic             tmo_err
);
  localparam int GAP_W = $clog2(CS_GAP + 1);
  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam int BC_W  = $clog2(FRAME_W);

  rd_state_t          state;
  logic [GAP_W-1:0]   gap_cnt;
  logic [TMO_W-1:0]   poll_cnt;
  logic [BC_W-1:0]    bit_cnt;
  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] frame_nxt;
  logic               sdo_s;
  logic               cap;
  logic               run;
  rd_result_t         dec;
  rd_result_t         out_q;

  adc_sdo_sync #(.STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (adc_sdo),
    .dout (sdo_s)
  );

  assign run = (state == ST_SHIFT);

  adc_sck_gen #(.HALF(SCK_HALF)) u_sck (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sck  (adc_sck),
    .cap  (cap)
  );

  assign frame_nxt = {shreg[FRAME_W-2:0], sdo_s};

  adc_frame_dec u_dec (
    .frame(frame_nxt),
    .res  (dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_GAP;
      gap_cnt   <= '0;
      poll_cnt  <= '0;
      bit_cnt   <= '0;
      shreg     <= '0;
      adc_csn   <= 1'b1;
      res_valid <= 1'b0;
      out_q     <= '0;
      irq       <= 1'b0;
      tmo_err   <= 1'b0;
    end else begin
      irq     <= 1'b0;
      tmo_err <= 1'b0;
      if (res_valid && res_ready) res_valid <= 1'b0;
      unique case (state)
        ST_GAP: begin
          adc_csn <= 1'b1;
          if (gap_cnt != GAP_W'(CS_GAP)) begin
            gap_cnt <= gap_cnt + 1'b1;
          end else if (!res_valid) begin
            state    <= ST_POLL;
            adc_csn  <= 1'b0;
            poll_cnt <= '0;
          end
        end
        ST_POLL: begin
          poll_cnt <= poll_cnt + 1'b1;
          if (poll_cnt >= TMO_W'(SETTLE) && !sdo_s) begin
            state   <= ST_SHIFT;
            bit_cnt <= '0;
            irq     <= irq_en;
          end else if (poll_cnt == TMO_W'(TMO_CYC)) begin
            state   <= ST_GAP;
            tmo_err <= 1'b1;
            adc_csn <= 1'b1;
            gap_cnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (cap) begin
            shreg   <= frame_nxt;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BC_W'(FRAME_W - 1)) begin
              state     <= ST_GAP;
              adc_csn   <= 1'b1;
              gap_cnt   <= '0;
              res_valid <= 1'b1;
              out_q     <= dec;
            end
          end
        end
        default: state <= ST_GAP;
      endcase
    end
  end

  assign res_data = out_q.value;
  assign res_ovr  = out_q.ovr;
  assign res_udr  = out_q.udr;
  assign res_ferr = out_q.ferr;
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
  parameter int SCK_HALF = 4,
  parameter int CS_GAP   = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_en,
  input logic        adc_csn,
  input logic        adc_sck,
  input logic        res_valid,
  input logic        res_ready,
  input logic [21:0] res_data,
  input logic        res_ovr,
  input logic        res_udr,
  input logic        res_ferr,
  input logic        irq,
  input logic        tmo_err
);
  logic        sck_q;
  logic [5:0]  pcnt;
  logic [15:0] hcnt;
  logic [15:0] gcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      pcnt  <= '0;
      hcnt  <= '0;
      gcnt  <= '0;
    end else begin
      sck_q <= adc_sck;
      if (adc_csn)                pcnt <= '0;
      else if (adc_sck && !sck_q) pcnt <= pcnt + 1'b1;
      if (adc_sck) hcnt <= hcnt + 1'b1;
      else         hcnt <= '0;
      if (!adc_csn)                    gcnt <= '0;
      else if (gcnt != 16'(CS_GAP))    gcnt <= gcnt + 1'b1;
    end
  end

  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_csn |-> !adc_sck);
  p_pulse_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_csn) |-> (pcnt == 6'd0 || pcnt == 6'd24));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_ovr)
                                   && $stable(res_udr) && $stable(res_ferr)));
  p_no_read_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> adc_csn);
  p_range_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_ovr && res_udr));
  p_min_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_csn) |-> (gcnt >= 16'(CS_GAP)));
  p_irq_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !adc_csn);
  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);
  p_tmo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> (adc_csn && !res_valid && !irq));
  p_duty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sck) |-> (hcnt == 16'(SCK_HALF)));
endmodule

bind adc_rd_ctrl adc_rd_chk #(.SCK_HALF(SCK_HALF), .CS_GAP(CS_GAP)) u_rd_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_en   (irq_en),
  .adc_csn  (adc_csn),
  .adc_sck  (adc_sck),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .res_data (res_data),
  .res_ovr  (res_ovr),
  .res_udr  (res_udr),
  .res_ferr (res_ferr),
  .irq      (irq),
  .tmo_err  (tmo_err)
);

// File: tb/tb_adc_rd_ctrl.sv
module tb_adc_rd_ctrl;
  localparam int HALF = 3;
  localparam int GAP  = 8;
  localparam int TMO  = 300;
  localparam int NV   = 6;

  // frame, expected value, expected {ovr,udr,ferr}, busy cycles
  localparam logic [23:0] V_FRAME [NV] = '{24'h3FFFFF, 24'h200000, 24'h000000,
                                           24'h1FFFFF, 24'h612345, 24'h2AAAAA};
  localparam logic [21:0] V_DATA  [NV] = '{22'h1FFFFF, 22'h000000, 22'h200000,
                                           22'h3FFFFF, 22'h012345, 22'h0AAAAA};
  localparam logic [2:0]  V_FLAG  [NV] = '{3'b100, 3'b000, 3'b010,
                                           3'b000, 3'b001, 3'b000};
  localparam int          V_WAIT  [NV] = '{0, 5, 40, 150, 2, 7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_en = 1'b1;
  logic res_ready = 1'b0;
  logic m_sdo = 1'b1;
  logic adc_csn, adc_sck, res_valid, res_ovr, res_udr, res_ferr, irq, tmo_err;
  logic [21:0] res_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  adc_rd_ctrl #(.SCK_HALF(HALF), .CS_GAP(GAP), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .adc_sdo(m_sdo),
    .adc_csn(adc_csn), .adc_sck(adc_sck), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_ovr(res_ovr),
    .res_udr(res_udr), .res_ferr(res_ferr), .irq(irq), .tmo_err(tmo_err)
  );

  // converter model and monitors, all on the falling edge
  logic [23:0] m_frame = '0;
  int m_wait = 1000000;
  int m_k = 0, m_rises = 0;
  logic m_sck_q = 1'b0, m_csn_q = 1'b1;
  int pcnt = 0, last_p = -1, since_rise = 0, bad_period = 0, bad_high = 0, hcnt = 0;
  int early_sck = 0, gcnt = 0, min_gap = 1000000, irq_cnt = 0, tmo_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      since_rise++;
      if (!adc_csn && adc_sck && !m_sck_q) begin
        if (m_wait != 0) early_sck++;
        if (pcnt > 0 && since_rise != 2*HALF) bad_period++;
        pcnt++;
        since_rise = 0;
      end
      if (adc_sck) hcnt++;
      else begin
        if (m_sck_q && hcnt != HALF) bad_high++;
        hcnt = 0;
      end
      if (adc_csn && !m_csn_q) begin last_p = pcnt; pcnt = 0; end
      if (adc_csn) gcnt++;
      else begin
        if (m_csn_q && gcnt < min_gap) min_gap = gcnt;
        gcnt = 0;
      end
      if (irq) irq_cnt++;
      if (tmo_err) tmo_cnt++;
    end
    if (m_wait > 0) m_wait--;
    if (adc_csn) begin
      if (m_rises >= 24) m_wait = 1000000;
      m_rises = 0;
      m_k = 0;
      m_sdo = 1'b1;
    end else begin
      if (adc_sck && !m_sck_q) m_rises++;
      if (!adc_sck && m_sck_q) m_k++;
      if (m_wait != 0 || m_k > 23) m_sdo = 1'b1;
      else m_sdo = m_frame[23-m_k];
    end
    m_sck_q = adc_sck;
    m_csn_q = adc_csn;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [23:0] f, input int w);
    @(posedge clk); #1;
    m_frame = f;
    m_wait = w;
    irq_cnt = 0;
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int c = 0; c < 5000 && !got; c++) begin
      @(negedge clk);
      if (res_valid) got = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic accept();
    @(posedge clk); #1 res_ready = 1'b1;
    @(posedge clk); #1 res_ready = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    bit got;
    logic [21:0] held;
    int csn_low, changed;
    repeat (3) @(negedge clk);
    chk(adc_csn === 1'b1 && adc_sck === 1'b0 && res_valid === 1'b0, "R1 reset outputs",
        {adc_csn, adc_sck, res_valid}, 3'b100);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(irq === 1'b0 && tmo_err === 1'b0, "R1 pulses idle", {irq, tmo_err}, 0);

    // table-driven reads
    for (int i = 0; i < NV; i++) begin
      load(V_FRAME[i], V_WAIT[i]);
      wait_valid(got);
      chk(got, "R7 result valid", got, 1);
      chk(res_data === V_DATA[i], "R4 value", res_data, V_DATA[i]);
      chk({res_ovr, res_udr} === V_FLAG[i][2:1], "R5 range flags", {res_ovr, res_udr}, V_FLAG[i][2:1]);
      chk(res_ferr === V_FLAG[i][0], "R6 framing", res_ferr, V_FLAG[i][0]);
      chk(last_p == 24, "R3 pulse count", last_p, 24);
      chk(irq_cnt == 1, "R10 irq once", irq_cnt, 1);
      accept();
    end
    chk(early_sck == 0, "R2 no clock while busy", early_sck, 0);
    chk(bad_high == 0 && bad_period == 0, "R11 duty and period", bad_high + bad_period, 0);
    chk(min_gap >= GAP, "R8 chip-select gap", min_gap, GAP);

    // back-pressure: result held, no read started
    load(24'h2ABCDE, 4);
    wait_valid(got);
    held = res_data;
    csn_low = 0; changed = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (!adc_csn) csn_low++;
      if (!res_valid || res_data !== held) changed++;
    end
    chk(csn_low == 0, "R7 no read while pending", csn_low, 0);
    chk(changed == 0 && held === 22'h0ABCDE, "R7 held payload", held, 22'h0ABCDE);
    accept();

    // timeout: busy never falls
    tmo_cnt = 0;
    got = 1'b0;
    for (int c = 0; c < 2000 && !got; c++) begin
      @(negedge clk);
      if (tmo_cnt > 0) got = 1'b1;
    end
    @(negedge clk);
    chk(got && tmo_cnt == 1, "R9 timeout pulse", tmo_cnt, 1);
    chk(adc_csn === 1'b1 && res_valid === 1'b0, "R9 released, no result", {adc_csn, res_valid}, 2'b10);
    chk(last_p == 0, "R9 no clock pulses", last_p, 0);

    // recovery with interrupt disabled
    @(posedge clk); #1 irq_en = 1'b0;
    load(24'h000001, 3);
    wait_valid(got);
    chk(got && res_data === 22'h200001 && res_udr === 1'b1, "R4 recovery read", res_data, 22'h200001);
    chk(irq_cnt == 0, "R10 irq disabled", irq_cnt, 0);
    chk(min_gap >= GAP, "R8 gap after timeout", min_gap, GAP);
    accept();
    summary();
  end
endmodule